// File: doc/BRIEF.md
# Accumulator Processor with Counter-Sequenced Control

This block is a very small processor. It has an 8-bit accumulator and a 6-bit program counter. Programs and data share one 64-byte memory. Every instruction is one byte: a 2-bit operation code in the top bits and a 6-bit operand address below it. Four operations exist:

- add a memory byte to the accumulator;
- AND a memory byte into the accumulator;
- jump to an address;
- increment the accumulator.

Internally, an address register, a data register and an instruction register join the two visible registers on one 8-bit internal bus. That bus is a multiplexer steered by three source-select strobes. A two-way ALU returns either the sum or the bitwise AND of the accumulator and the data register.

Control is hardwired. A 4-bit state counter can clear, load or count up. A one-hot decoder turns the count into a single active state line. Each control strobe is the OR of the state lines that need it. After reset, execution starts at address 0. The surrounding system supplies a memory whose read data is valid in the same cycle the address register drives it, and it can watch the accumulator and program counter on debug outputs.

Top module: `acc_cpu`

## Requirements
- R1: While the synchronous active-high reset is asserted, the program counter and accumulator become 0 and the sequencer returns to its first fetch state. The first memory read after release is at address 0.
- R2: Opcode 00 adds the byte at the operand address to the accumulator, modulo 256, with no carry kept.
- R3: Opcode 01 replaces the accumulator with its bitwise AND with the byte at the operand address.
- R4: Opcode 10 loads the 6-bit operand field into the program counter. The accumulator is left unchanged.
- R5: Opcode 11 adds 1 to the accumulator, modulo 256. Its low six bits are ignored and cause no memory access.
- R6: The program counter counts modulo 64, so the instruction after address 63 is fetched from address 0.
- R7: Every instruction spends three fetch cycles. Add and AND then take two more cycles, and jump and increment take one more. The accumulator and program counter change only on the final edge of their own instruction, or on the fetch edge that advances the program counter.
- R8: The memory read strobe is high once per instruction, at the program counter's address. It is high once more only for add and AND, at the operand address. At most one source drives the internal bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 6 | Memory address, driven from the address register |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the cycle the read strobe is high |
| dbg_acc | output | 8 | Current accumulator value |
| dbg_pc | output | 6 | Current program counter value |

## Verification
The directed programs cover each opcode, and each one separates a specific mistake.

- Add operands are chosen to overflow past 255, which shows whether the sum wraps.
- AND operands are chosen so that bits from either side alone would leave a different result.
- The increment instruction carries all-ones address bits that point at a non-zero byte. If the decode treated it as an add, the accumulator would differ.
- A jump is placed near the top of memory so that sequential execution must wrap through address 0.
- The accumulator and program counter are sampled one cycle before and one cycle after each instruction's last edge. The log of read addresses shows which instructions fetch an operand.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int OP_W    = DATA_W - ADDR_W;
    localparam int STATE_W = 4;
    localparam int NSTATES = 1 << STATE_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'b00,
        OP_AND = 2'b01,
        OP_JMP = 2'b10,
        OP_INC = 2'b11
    } opcode_e;

    // Execute states sit at {1, opcode, step}, so the dispatch is a plain load.
    typedef enum logic [STATE_W-1:0] {
        ST_FETCH1 = 4'd0,
        ST_FETCH2 = 4'd1,
        ST_FETCH3 = 4'd2,
        ST_ADD1   = 4'd8,
        ST_ADD2   = 4'd9,
        ST_AND1   = 4'd10,
        ST_AND2   = 4'd11,
        ST_JMP1   = 4'd12,
        ST_INC1   = 4'd14
    } state_e;

    typedef struct packed {
        logic ar_load;
        logic pc_load;
        logic dr_load;
        logic ac_load;
        logic ir_load;
        logic pc_inc;
        logic ac_inc;
        logic pc_drive;
        logic dr_drive;
        logic mem_drive;
        logic mem_read;
        logic alu_and;
    } ctrl_t;

    typedef struct packed {
        logic clear;
        logic load;
        logic inc;
    } seq_t;

    function automatic logic [STATE_W-1:0] dispatch_state(opcode_e op);
        return {1'b1, op, 1'b0};
    endfunction

    function automatic logic [NSTATES-1:0] valid_mask();
        logic [NSTATES-1:0] m;
        m = '0;
        m[ST_FETCH1] = 1'b1;
        m[ST_FETCH2] = 1'b1;
        m[ST_FETCH3] = 1'b1;
        m[ST_ADD1]   = 1'b1;
        m[ST_ADD2]   = 1'b1;
        m[ST_AND1]   = 1'b1;
        m[ST_AND2]   = 1'b1;
        m[ST_JMP1]   = 1'b1;
        m[ST_INC1]   = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/acc_cpu_seqctr.sv
module acc_cpu_seqctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (ld) begin
            q <= din;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/acc_cpu_decoder.sv
module acc_cpu_decoder #(
    parameter int W = 4,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] code,
    output logic [N-1:0] lines
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign lines[i] = (code == W'(i));
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int SW = STATE_W,
    localparam int N = 1 << SW
) (
    input  logic    clk,
    input  logic    rst,
    input  opcode_e ir,
    output ctrl_t   ctl
);
    logic [SW-1:0] state;
    logic [N-1:0]  line;
    logic [N-1:0]  known;
    logic          stray;
    seq_t          seq;

    acc_cpu_seqctr #(.W(SW)) u_ctr (
        .clk (clk),
        .rst (rst),
        .clr (seq.clear),
        .ld  (seq.load),
        .inc (seq.inc),
        .din (SW'(dispatch_state(ir))),
        .q   (state)
    );

    acc_cpu_decoder #(.W(SW)) u_dec (
        .code  (state),
        .lines (line)
    );

    assign known = N'(valid_mask());
    assign stray = ~|(line & known);

    always_comb begin
        ctl = '0;
        ctl.ar_load   = line[ST_FETCH1] | line[ST_FETCH3];
        ctl.pc_load   = line[ST_JMP1];
        ctl.dr_load   = line[ST_FETCH2] | line[ST_ADD1] | line[ST_AND1];
        ctl.ac_load   = line[ST_ADD2] | line[ST_AND2];
        ctl.ir_load   = line[ST_FETCH2];
        ctl.pc_inc    = line[ST_FETCH2];
        ctl.ac_inc    = line[ST_INC1];
        ctl.pc_drive  = line[ST_FETCH1];
        ctl.dr_drive  = line[ST_FETCH3] | line[ST_JMP1];
        ctl.mem_drive = line[ST_FETCH2] | line[ST_ADD1] | line[ST_AND1];
        ctl.mem_read  = line[ST_FETCH2] | line[ST_ADD1] | line[ST_AND1];
        ctl.alu_and   = line[ST_AND2];
    end

    always_comb begin
        seq.clear = line[ST_ADD2] | line[ST_AND2] | line[ST_JMP1]
                  | line[ST_INC1] | stray;
        seq.load  = line[ST_FETCH3];
        seq.inc   = ~seq.clear & ~seq.load;
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int W = 8
) (
    input  logic         sel_and,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] sum;
    logic [W-1:0] conj;

    assign sum  = a + b;
    assign conj = a & b;
    assign y    = sel_and ? conj : sum;
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] ar,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] dr,
    output logic [DW-1:0] ac,
    output opcode_e       ir
);
    logic [DW-1:0] bus;
    logic [DW-1:0] alu_y;

    always_comb begin
        unique case ({ctl.pc_drive, ctl.dr_drive, ctl.mem_drive})
            3'b100:  bus = DW'(pc);
            3'b010:  bus = dr;
            3'b001:  bus = mem_rdata;
            default: bus = '0;
        endcase
    end

    acc_cpu_alu #(.W(DW)) u_alu (
        .sel_and (ctl.alu_and),
        .a       (ac),
        .b       (dr),
        .y       (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ar <= '0;
            pc <= '0;
            dr <= '0;
            ac <= '0;
            ir <= OP_ADD;
        end else begin
            if (ctl.ar_load) ar <= bus[AW-1:0];
            if (ctl.pc_load) pc <= bus[AW-1:0];
            else if (ctl.pc_inc) pc <= pc + AW'(1);
            if (ctl.dr_load) dr <= bus;
            if (ctl.ir_load) ir <= opcode_e'(bus[DW-1:AW]);
            if (ctl.ac_load) ac <= alu_y;
            else if (ctl.ac_inc) ac <= ac + DW'(1);
        end
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dbg_acc,
    output logic [ADDR_W-1:0] dbg_pc
);
    ctrl_t             ctl;
    opcode_e           ir_q;
    logic [DATA_W-1:0] dr_q;
    logic [ADDR_W-1:0] ar_q;

    acc_cpu_ctrl #(.SW(STATE_W)) u_ctrl (
        .clk (clk),
        .rst (rst),
        .ir  (ir_q),
        .ctl (ctl)
    );

    acc_cpu_dp #(.DW(DATA_W), .AW(ADDR_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .ar        (ar_q),
        .pc        (dbg_pc),
        .dr        (dr_q),
        .ac        (dbg_acc),
        .ir        (ir_q)
    );

    assign mem_addr = ar_q;
    assign mem_rd   = ctl.mem_read;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input ctrl_t             ctl,
    input logic [DATA_W-1:0] dr_q,
    input logic [DATA_W-1:0] dbg_acc,
    input logic [ADDR_W-1:0] dbg_pc,
    input logic              mem_rd
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0 && dbg_acc == '0));

    assert_jump_target_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_load |=> dbg_pc == $past(dr_q[ADDR_W-1:0]));

    assert_inc_wraps_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.ac_inc |=> dbg_acc == DATA_W'($past(dbg_acc) + 1));

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_inc |=> dbg_pc == ADDR_W'($past(dbg_pc) + 1));

    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pc_inc && !ctl.pc_load) |=> $stable(dbg_pc));

    assert_acc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctl.ac_inc && !ctl.ac_load) |=> $stable(dbg_acc));

    assert_bus_single_R8: assert property (@(posedge clk) disable iff (rst)
        $countones({ctl.pc_drive, ctl.dr_drive, ctl.mem_drive}) <= 1);

    assert_read_lands_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (ctl.dr_load && !ctl.ac_load && !ctl.pc_load));
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .dr_q    (dr_q),
    .dbg_acc (dbg_acc),
    .dbg_pc  (dbg_pc),
    .mem_rd  (mem_rd)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] mem_addr;
    logic       mem_rd;
    logic [7:0] mem_rdata;
    logic [7:0] dbg_acc;
    logic [5:0] dbg_pc;

    logic [7:0] mem [64];
    int total = 0;
    int bad = 0;
    int rd_n = 0;
    int rd_base = 0;
    logic [5:0] rd_log [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    acc_cpu u_acc_cpu (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .dbg_acc   (dbg_acc),
        .dbg_pc    (dbg_pc)
    );

    always @(negedge clk) begin
        if (!rst && mem_rd) begin
            rd_log[rd_n % 256] = mem_addr;
            rd_n = rd_n + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd_base = rd_n;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        clear_mem();
        do_reset();
        check("R1 pc after reset", dbg_pc, 0);
        check("R1 acc after reset", dbg_acc, 0);
        run(1);
        check("R1 first read strobe", mem_rd, 1);
        check("R1 first read address", mem_addr, 0);
        run(1);
        check("R6 pc steps after fetch", dbg_pc, 1);
    endtask

    task automatic test_add();
        clear_mem();
        mem[0] = 8'hC0; mem[1] = 8'h20; mem[2] = 8'h21; mem[3] = 8'h83;
        mem[8'h20] = 8'h7F; mem[8'h21] = 8'h90;
        do_reset();
        run(4);
        check("R5 inc from zero", dbg_acc, 8'h01);
        run(4);
        check("R7 add not yet written", dbg_acc, 8'h01);
        run(1);
        check("R2 add result", dbg_acc, 8'h80);
        run(5);
        check("R2 add wraps modulo 256", dbg_acc, 8'h10);
        check("R7 pc after three instructions", dbg_pc, 3);
        check("R8 read count", rd_n - rd_base, 5);
        check("R8 read 0 address", rd_log[(rd_base + 0) % 256], 6'h00);
        check("R8 read 1 address", rd_log[(rd_base + 1) % 256], 6'h01);
        check("R8 read 2 operand", rd_log[(rd_base + 2) % 256], 6'h20);
        check("R8 read 3 address", rd_log[(rd_base + 3) % 256], 6'h02);
        check("R8 read 4 operand", rd_log[(rd_base + 4) % 256], 6'h21);
    endtask

    task automatic test_and();
        clear_mem();
        mem[0] = 8'h30; mem[1] = 8'h71; mem[2] = 8'h72; mem[3] = 8'h73;
        mem[4] = 8'h84;
        mem[8'h30] = 8'hF3; mem[8'h31] = 8'h5C; mem[8'h32] = 8'hFF;
        mem[8'h33] = 8'h0F;
        do_reset();
        run(5);
        check("R2 load via add", dbg_acc, 8'hF3);
        run(5);
        check("R3 and mixed bits", dbg_acc, 8'h50);
        run(5);
        check("R3 and with all ones", dbg_acc, 8'h50);
        run(5);
        check("R3 and to zero", dbg_acc, 8'h00);
    endtask

    task automatic test_jmp();
        clear_mem();
        mem[0] = 8'hAA; mem[8'h2A] = 8'hC0; mem[8'h2B] = 8'h85;
        mem[5] = 8'hC0; mem[6] = 8'h86;
        do_reset();
        run(3);
        check("R7 pc before jump edge", dbg_pc, 1);
        run(1);
        check("R4 jump target", dbg_pc, 6'h2A);
        check("R4 acc untouched by jump", dbg_acc, 0);
        check("R8 jump makes no operand read", rd_n - rd_base, 1);
        run(4);
        check("R4 executes at target acc", dbg_acc, 1);
        check("R4 executes at target pc", dbg_pc, 6'h2B);
        run(4);
        check("R4 backward jump", dbg_pc, 5);
        run(4);
        check("R4 acc after second inc", dbg_acc, 2);
        check("R4 pc after second inc", dbg_pc, 6);
    endtask

    task automatic test_inc();
        clear_mem();
        mem[0] = 8'h10; mem[1] = 8'hFF; mem[2] = 8'hD5; mem[3] = 8'h83;
        mem[8'h10] = 8'hFE; mem[8'h3F] = 8'h55; mem[8'h15] = 8'h33;
        do_reset();
        run(5);
        check("R2 preload", dbg_acc, 8'hFE);
        run(4);
        check("R5 inc ignores address bits", dbg_acc, 8'hFF);
        check("R5 inc makes no operand read", rd_n - rd_base, 3);
        run(4);
        check("R5 inc wraps to zero", dbg_acc, 8'h00);
        check("R5 read count after second inc", rd_n - rd_base, 4);
        run(6);
        do_reset();
        check("R1 reset mid-program pc", dbg_pc, 0);
        check("R1 reset mid-program acc", dbg_acc, 0);
    endtask

    task automatic test_pcwrap();
        clear_mem();
        mem[0] = 8'hBE; mem[8'h3E] = 8'hC0; mem[8'h3F] = 8'hC0;
        do_reset();
        run(4);
        check("R6 jump near top", dbg_pc, 6'h3E);
        run(4);
        check("R6 pc at last address", dbg_pc, 6'h3F);
        run(4);
        check("R6 pc wraps to zero", dbg_pc, 0);
        check("R6 acc after two incs", dbg_acc, 2);
        run(1);
        check("R6 fetch from address zero", mem_addr, 0);
        check("R6 fetch strobe after wrap", mem_rd, 1);
    endtask

    initial begin
        bit wd_hit;
        wd_hit = 1'b0;
        fork
            begin
                test_reset();
                test_add();
                test_and();
                test_jmp();
                test_inc();
                test_pcwrap();
            end
            begin
                repeat (20000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule